// File: doc/BRIEF.md
# Single-Precision Normalize, Round and Pack Unit

This unit is the last stage of a single-precision arithmetic datapath. It takes an unpacked intermediate value and returns a packed 32-bit IEEE-754 word with three exception flags: inexact, overflow and underflow. The intermediate value has three parts. The sign is one bit. The exponent is a signed, biased integer one below the packed field. The significand is 32 bits, and its lowest eight bits sit under the result's least significant bit. The unit shifts the leading one of the significand up to bit 31. A tiny value is shifted back right, and any bits it loses are folded into a sticky bit. The value is then rounded in one of four modes, and the rounding carry and the overflow are settled before packing.

Upstream logic computes sums, products or conversions in the intermediate form and feeds them straight in. An infinity, or a NaN that already has an exception pending, passes through without rounding. The path is combinational. A parameter can add one register stage at the output.

Top module: `fp32_norm_round_pack`

## Requirements
- R1: When `in_exp` equals 255 and either `in_sig` is zero or `in_pend` is 1, `res` is {in_sign, in_exp[7:0], in_sig[29:7]} and all flags are 0.
- R2: Otherwise, a zero `in_sig` gives `res` = {in_sign, 31'b0} with all flags 0, whatever the exponent.
- R3: A nonzero significand is shifted left until bit 31 is one, and the exponent drops by the same count. The packed word is then {sign, 8'b0, 23'b0} + (E << 23) + (S >> 8), where E is the final exponent and S the rounded significand. The hidden bit therefore adds one to the field, and 1.0 arrives as exponent 126, significand 0x80000000.
- R4: `rnd_mode` 2'b00 rounds to nearest. Below bit 8 it adds 0x80 when bit 8 is 1 and 0x7F when bit 8 is 0, so exact ties go to even.
- R5: `rnd_mode` 2'b11 truncates and adds nothing.
- R6: `rnd_mode` 2'b01 (toward +infinity) and 2'b10 (toward -infinity) add 0xFF when (mode is 2'b01) XOR sign is true, and add nothing otherwise.
- R7: When the increment would carry out of bit 31, the exponent goes up by one and the significand shifts right by one with its old bit 0 ORed back into bit 0. The increment is halved before it is added.
- R8: `flag_nx` is 1 when bits 7..0 are nonzero before the increment is added, and also on overflow.
- R9: An exponent of 254 or more after the carry step sets `flag_of` and `flag_nx`. The result is a signed infinity when the increment is nonzero, and the signed largest finite value (field 0xFE, fraction all ones) when it is zero.
- R10: After normalization, a negative exponent E shifts the significand right by -E. Any lost bit is ORed into bit 0, a shift of 32 or more leaves only that sticky bit, and E becomes 0. If the rounded significand has no bits above bit 7, the exponent field is 0.
- R11: `flag_uf` is 1 only in one case: the value was tiny, its guard bits were nonzero after the right shift, its final exponent is 0, and its rounded significand is not above 0x80000000.
- R12: With OUT_REG=1, `res` and the flags show the result of the inputs present at the previous rising edge of `clk`. While `rst_n` is low they are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | EXP_W | Signed biased exponent (one below the packed field) |
| in_sig | input | 32 | Significand with eight guard bits at the bottom |
| in_pend | input | 1 | An exception is already pending for this value |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero |
| res | output | 32 | Packed single-precision result |
| flag_nx | output | 1 | Inexact |
| flag_of | output | 1 | Overflow |
| flag_uf | output | 1 | Underflow |

## Verification
The bench builds the unit with EXP_W=12 and OUT_REG=1. The 12-bit exponent lets it drive deep negative exponents such as -100, which push the tiny right shift past the 32-bit width and test the sticky-only path. The same width also reaches exponents above 255 and the exact value 255 used by the pass-through case. The output register brings in reset values and the one-cycle latency, and these are checked by holding the old output while new inputs are applied.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
   localparam int SIG_W = 32;
   localparam int GRD_W = 8;
   localparam int FRC_W = 23;
   localparam int EFL_W = 8;
   localparam int SHW   = $clog2(SIG_W);

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_UP   = 2'b01,
      RM_DOWN = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;

   typedef struct packed {
      logic nx;
      logic of;
      logic uf;
   } fflags_t;
endpackage

// File: rtl/nrp_norm.sv
module nrp_norm
   import nrp_pkg::*;
#(
   parameter int XW = 13
) (
   input  logic [SIG_W-1:0]    sig_i,
   input  logic signed [XW-1:0] exp_i,
   output logic [SIG_W-1:0]    sig_o,
   output logic signed [XW-1:0] exp_o
);
   localparam int LZW = SHW + 1;

   logic [LZW-1:0] lz;

   // leading-one search: the highest set bit wins (last assignment)
   always_comb begin
      lz = '0;
      for (int i = 0; i < SIG_W; i++) begin
         if (sig_i[i]) lz = LZW'(SIG_W - 1 - i);
      end
   end

   assign sig_o = sig_i << lz;
   assign exp_o = exp_i - $signed({{(XW-LZW){1'b0}}, lz});
endmodule

// File: rtl/nrp_round.sv
module nrp_round
   import nrp_pkg::*;
#(
   parameter int XW = 13
) (
   input  logic                 sign_i,
   input  logic [1:0]           mode_i,
   input  logic [SIG_W-1:0]     sig_i,
   input  logic signed [XW-1:0] exp_i,
   output logic [SIG_W-1:0]     sig_o,
   output logic signed [XW-1:0] exp_o,
   output logic                 inc_nz_o,
   output logic                 nx_o,
   output logic                 tiny_o
);
   localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W - 1);
   localparam logic [GRD_W-1:0] ALL1 = '1;

   logic                  neg_exp;
   logic [XW-1:0]         amt;
   logic [2*SIG_W-1:0]    wide;
   logic [SIG_W-1:0]      tsig, asig;
   logic signed [XW-1:0]  texp;
   logic [GRD_W-1:0]      inc0, inc;
   logic [SIG_W:0]        trial;

   // tiny path: sticky right shift back to exponent zero
   always_comb begin
      neg_exp = exp_i < 0;
      amt     = -exp_i;
      wide    = {sig_i, {SIG_W{1'b0}}} >> amt[SHW-1:0];
      tsig    = sig_i;
      texp    = exp_i;
      if (neg_exp) begin
         texp = '0;
         if (amt >= XW'(SIG_W)) tsig = {{(SIG_W-1){1'b0}}, |sig_i};
         else                   tsig = wide[2*SIG_W-1:SIG_W] | {{(SIG_W-1){1'b0}}, |wide[SIG_W-1:0]};
      end
   end

   assign tiny_o = neg_exp && (tsig[GRD_W-1:0] != '0);

   // increment selection per rounding mode
   always_comb begin
      case (mode_i)
         RM_NEAR: inc0 = tsig[GRD_W] ? HALF : HALF - GRD_W'(1);
         RM_ZERO: inc0 = '0;
         default: inc0 = ((mode_i == RM_UP) ^ sign_i) ? ALL1 : '0;
      endcase
   end

   // carry-out absorption, then the actual rounding add
   always_comb begin
      trial = {1'b0, tsig} + {{(SIG_W+1-GRD_W){1'b0}}, inc0};
      if (trial[SIG_W]) begin
         asig  = {1'b0, tsig[SIG_W-1:1]} | {{(SIG_W-1){1'b0}}, tsig[0]};
         exp_o = texp + XW'(1);
         inc   = inc0 >> 1;
      end else begin
         asig  = tsig;
         exp_o = texp;
         inc   = inc0;
      end
      nx_o     = asig[GRD_W-1:0] != '0;
      sig_o    = asig + {{(SIG_W-GRD_W){1'b0}}, inc};
      inc_nz_o = inc != '0;
   end
endmodule

// File: rtl/nrp_pack.sv
module nrp_pack
   import nrp_pkg::*;
#(
   parameter int EXP_W = 12,
   parameter int XW    = 13
) (
   input  logic                    sign_i,
   input  logic signed [EXP_W-1:0] raw_exp_i,
   input  logic [SIG_W-1:0]        raw_sig_i,
   input  logic                    pend_i,
   input  logic [SIG_W-1:0]        rsig_i,
   input  logic signed [XW-1:0]    rexp_i,
   input  logic                    inc_nz_i,
   input  logic                    nx_i,
   input  logic                    tiny_i,
   output logic [SIG_W-1:0]        res_o,
   output fflags_t                 flags_o
);
   localparam logic [EFL_W-1:0] EMAX = '1;
   localparam logic [SIG_W-1:0] HIDDEN_ONLY = SIG_W'(1) << (SIG_W - 1);

   logic             bypass;
   logic [EFL_W-1:0] fexp;
   logic [SIG_W-2:0] body;

   assign bypass = (raw_exp_i == EXP_W'(255)) && ((raw_sig_i == '0) || pend_i);

   always_comb begin
      res_o   = '0;
      flags_o = '0;
      fexp    = rexp_i[EFL_W-1:0];
      body    = '0;
      if (bypass) begin
         res_o = {sign_i, raw_exp_i[EFL_W-1:0], raw_sig_i[SIG_W-3 -: FRC_W]};
      end else if (raw_sig_i == '0) begin
         res_o = {sign_i, {(SIG_W-1){1'b0}}};
      end else if (rexp_i >= $signed(XW'(254))) begin
         flags_o.of = 1'b1;
         flags_o.nx = 1'b1;
         res_o = inc_nz_i ? {sign_i, EMAX, {FRC_W{1'b0}}}
                          : {sign_i, EMAX - EFL_W'(1), {FRC_W{1'b1}}};
      end else begin
         if (rsig_i[SIG_W-1:GRD_W] == '0) fexp = '0;
         body       = {fexp, {FRC_W{1'b0}}} + {{(SIG_W-1-(SIG_W-GRD_W)){1'b0}}, rsig_i[SIG_W-1:GRD_W]};
         res_o      = {sign_i, body};
         flags_o.nx = nx_i;
         flags_o.uf = tiny_i && (fexp == '0) && !(rsig_i > HIDDEN_ONLY);
      end
   end
endmodule

// File: rtl/fp32_norm_round_pack.sv
module fp32_norm_round_pack
   import nrp_pkg::*;
#(
   parameter int EXP_W   = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_sign,
   input  logic signed [EXP_W-1:0] in_exp,
   input  logic [31:0]             in_sig,
   input  logic                    in_pend,
   input  logic [1:0]              rnd_mode,
   output logic [31:0]             res,
   output logic                    flag_nx,
   output logic                    flag_of,
   output logic                    flag_uf
);
   localparam int XW = EXP_W + 1;

   if (EXP_W < 10 || EXP_W > 24) begin : g_bad_exp_w
      $error("fp32_norm_round_pack: EXP_W must lie in 10..24");
   end

   logic [SIG_W-1:0]     n_sig, r_sig, c_res;
   logic signed [XW-1:0] n_exp, r_exp;
   logic                 r_inc_nz, r_nx, r_tiny;
   fflags_t              c_flags;

   nrp_norm #(.XW(XW)) u_norm (
      .sig_i (in_sig),
      .exp_i ({in_exp[EXP_W-1], in_exp}),
      .sig_o (n_sig),
      .exp_o (n_exp)
   );

   nrp_round #(.XW(XW)) u_round (
      .sign_i   (in_sign),
      .mode_i   (rnd_mode),
      .sig_i    (n_sig),
      .exp_i    (n_exp),
      .sig_o    (r_sig),
      .exp_o    (r_exp),
      .inc_nz_o (r_inc_nz),
      .nx_o     (r_nx),
      .tiny_o   (r_tiny)
   );

   nrp_pack #(.EXP_W(EXP_W), .XW(XW)) u_pack (
      .sign_i    (in_sign),
      .raw_exp_i (in_exp),
      .raw_sig_i (in_sig),
      .pend_i    (in_pend),
      .rsig_i    (r_sig),
      .rexp_i    (r_exp),
      .inc_nz_i  (r_inc_nz),
      .nx_i      (r_nx),
      .tiny_i    (r_tiny),
      .res_o     (c_res),
      .flags_o   (c_flags)
   );

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res     <= '0;
            flag_nx <= 1'b0;
            flag_of <= 1'b0;
            flag_uf <= 1'b0;
         end else begin
            res     <= c_res;
            flag_nx <= c_flags.nx;
            flag_of <= c_flags.of;
            flag_uf <= c_flags.uf;
         end
      end

      // R12
      out_reg_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (res == $past(c_res)) && (flag_nx == $past(c_flags.nx)));
   end else begin : g_comb
      assign res     = c_res;
      assign flag_nx = c_flags.nx;
      assign flag_of = c_flags.of;
      assign flag_uf = c_flags.uf;
   end

   // R1
   pass_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exp == EXP_W'(255) && in_pend) |-> (c_flags == '0));
   // R2
   zero_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sig == '0 && in_exp != EXP_W'(255)) |-> (c_res == {in_sign, 31'b0} && c_flags == '0));
   // R9
   ovf_sets_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_flags.of |-> (c_flags.nx && c_res[30:23] >= 8'hFE));
   // R11
   uf_tiny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_flags.uf |-> (c_flags.nx && !c_flags.of && c_res[30:24] == '0));
endmodule

// File: tb/fp32_norm_round_pack_tb.sv
`timescale 1ns/1ps
module fp32_norm_round_pack_tb;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_sign = 1'b0;
   logic signed [11:0] in_exp = '0;
   logic [31:0]        in_sig = '0;
   logic               in_pend = 1'b0;
   logic [1:0]         rnd_mode = '0;
   logic [31:0]        res;
   logic               flag_nx, flag_of, flag_uf;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   fp32_norm_round_pack #(.EXP_W(12), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_exp(in_exp),
      .in_sig(in_sig), .in_pend(in_pend), .rnd_mode(rnd_mode),
      .res(res), .flag_nx(flag_nx), .flag_of(flag_of), .flag_uf(flag_uf)
   );

   // expected {res, nx, of, uf} from the requirement text
   function automatic logic [34:0] model(input logic sg, input int ex,
                                         input logic [31:0] sg_in, input logic pd,
                                         input logic [1:0] md);
      logic [31:0] s;
      int          e;
      logic [7:0]  inc;
      logic        nx, uf;
      logic [32:0] t;
      logic [63:0] w;
      logic [30:0] body;
      logic [7:0]  fe;
      if (ex == 255 && (sg_in == 0 || pd)) return {sg, ex[7:0], sg_in[29:7], 3'b000};
      if (sg_in == 0) return {sg, 31'b0, 3'b000};
      s = sg_in;
      e = ex;
      while (!s[31]) begin s = s << 1; e = e - 1; end
      uf = 1'b0;
      if (e < 0) begin
         if (-e >= 32) s = {31'b0, 1'b1};
         else begin
            w = {s, 32'b0} >> (-e);
            s = w[63:32] | {31'b0, (w[31:0] != 0)};
         end
         e  = 0;
         uf = (s[7:0] != 0);
      end
      if (md == 2'b00)      inc = s[8] ? 8'h80 : 8'h7F;
      else if (md == 2'b11) inc = 8'h00;
      else                  inc = ((md == 2'b01) ^ sg) ? 8'hFF : 8'h00;
      t = {1'b0, s} + {25'b0, inc};
      if (t[32]) begin
         e   = e + 1;
         s   = {1'b0, s[31:1]} | {31'b0, s[0]};
         inc = inc >> 1;
      end
      nx = (s[7:0] != 0);
      s  = s + {24'b0, inc};
      if (e >= 254) begin
         if (inc != 0) return {sg, 8'hFF, 23'h0, 3'b110};
         return {sg, 8'hFE, 23'h7FFFFF, 3'b110};
      end
      fe = (s[31:8] == 0) ? 8'd0 : e[7:0];
      if (fe != 0 || s > 32'h8000_0000) uf = 1'b0;
      body = {fe, 23'b0} + {7'b0, s[31:8]};
      return {sg, body, nx, 1'b0, uf};
   endfunction

   task automatic compare(input logic [34:0] want, input string tag);
      logic [34:0] got;
      got = {res, flag_nx, flag_of, flag_uf};
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: got res=%h nx/of/uf=%b expected res=%h nx/of/uf=%b",
                  tag, got[34:3], got[2:0], want[34:3], want[2:0]);
      end
   endtask

   // drive at a falling edge, result registered at the next rising edge
   task automatic apply(input logic sg, input int ex, input logic [31:0] sg_in,
                        input logic pd, input logic [1:0] md);
      @(negedge clk);
      in_sign = sg; in_exp = ex[11:0]; in_sig = sg_in; in_pend = pd; rnd_mode = md;
      @(negedge clk);
   endtask

   task automatic dir(input logic sg, input int ex, input logic [31:0] sg_in,
                      input logic pd, input logic [1:0] md,
                      input logic [34:0] lit, input string tag);
      apply(sg, ex, sg_in, pd, md);
      compare(lit, tag);
      compare(model(sg, ex, sg_in, pd, md), {tag, " model"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [34:0] prev;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12 reset state
      compare(35'h0, "R12 reset");
      rst_n = 1'b1;

      dir(1'b1, 255, 32'h0, 1'b0, 2'b00, {32'hFF800000, 3'b000}, "R1 infinity");
      dir(1'b0, 255, 32'h6000_0000, 1'b1, 2'b00, {32'h7FC00000, 3'b000}, "R1 pending nan");
      dir(1'b1, 50, 32'h0, 1'b0, 2'b01, {32'h80000000, 3'b000}, "R2 signed zero");
      dir(1'b0, 126, 32'h8000_0000, 1'b0, 2'b00, {32'h3F800000, 3'b000}, "R3 R8 one exact");
      dir(1'b0, 157, 32'h0000_0001, 1'b0, 2'b00, {32'h3F800000, 3'b000}, "R3 normalize shift");
      dir(1'b0, 126, 32'h8000_0080, 1'b0, 2'b00, {32'h3F800000, 3'b100}, "R4 tie to even down");
      dir(1'b0, 126, 32'h8000_0180, 1'b0, 2'b00, {32'h3F800002, 3'b100}, "R4 tie to even up");
      dir(1'b0, 126, 32'h8000_01FF, 1'b0, 2'b11, {32'h3F800001, 3'b100}, "R5 truncate");
      dir(1'b1, 126, 32'h8000_0001, 1'b0, 2'b10, {32'hBF800001, 3'b100}, "R6 down negative");
      dir(1'b1, 126, 32'h8000_0001, 1'b0, 2'b01, {32'hBF800000, 3'b100}, "R6 up negative");
      dir(1'b0, 126, 32'hFFFF_FFFF, 1'b0, 2'b00, {32'h40000000, 3'b100}, "R7 carry out");
      dir(1'b0, 253, 32'hFFFF_FFFF, 1'b0, 2'b00, {32'h7F800000, 3'b110}, "R9 to infinity");
      dir(1'b0, 254, 32'h8000_0000, 1'b0, 2'b11, {32'h7F7FFFFF, 3'b110}, "R9 max finite");
      dir(1'b1, 254, 32'h8000_0000, 1'b0, 2'b01, {32'hFF7FFFFF, 3'b110}, "R9 neg max finite");
      dir(1'b0, -1, 32'h8000_0001, 1'b0, 2'b00, {32'h00400000, 3'b101}, "R10 R11 tiny inexact");
      dir(1'b0, -1, 32'h8000_0000, 1'b0, 2'b00, {32'h00400000, 3'b000}, "R11 tiny exact");
      dir(1'b0, -1, 32'hFFFF_FFFF, 1'b0, 2'b00, {32'h00800000, 3'b100}, "R11 rounds to normal");
      dir(1'b0, -100, 32'h8000_0000, 1'b0, 2'b01, {32'h00000001, 3'b101}, "R10 deep sticky up");
      dir(1'b0, -100, 32'h8000_0000, 1'b0, 2'b00, {32'h00000000, 3'b101}, "R10 deep sticky zero");

      // R12 output holds until the next rising edge
      prev = {res, flag_nx, flag_of, flag_uf};
      @(negedge clk);
      in_sign = 1'b0; in_exp = 12'sd126; in_sig = 32'h8000_0000; in_pend = 1'b0; rnd_mode = 2'b00;
      #2;
      compare(prev, "R12 latency hold");
      @(negedge clk);
      compare({32'h3F800000, 3'b000}, "R12 latency update");

      for (int k = 0; k < 3000; k++) begin
         logic        sg, pd;
         int          ex;
         logic [31:0] sv;
         logic [1:0]  md;
         sg = 1'($urandom);
         md = 2'($urandom);
         pd = ($urandom_range(0, 3) == 0);
         ex = ($urandom_range(0, 9) == 0) ? 255 : int'($urandom_range(0, 330)) - 60;
         sv = $urandom >> $urandom_range(0, 33);
         if ($urandom_range(0, 7) == 0) sv = sv | 32'hFFFF_FF00;
         apply(sg, ex, sv, pd, md);
         compare(model(sg, ex, sv, pd, md), "R1..R11 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule